// File: doc/BRIEF.md
# Per-CPU GPIO Interrupt Mask Bank

This block sits behind the shared GPIO input path and gives every CPU in a cluster a private copy of the interrupt cause and mask state. The shared logic supplies two vectors each cycle. One is the polarity-corrected level of every line. The other is a one-cycle pulse for every line on which the edge detector fired. Each CPU latches those pulses into its own sticky cause register and applies its own edge and level masks. It can therefore acknowledge or mask a line without disturbing what any other CPU sees.

Software reaches the state through a small word-addressed register window. A CPU's edge-cause register sits at byte offset n*4. Its edge-mask register sits at 0x10 + n*4, and its level-mask register at 0x20 + n*4. For each CPU, the masked requests of the lines are folded in groups of eight into a set of summary interrupt outputs. These outputs feed the interrupt controller above.

Top module: `gpio_pcpu_irq_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every cause and mask register of every CPU is cleared. After that edge, `irq_grp` and `acc_rdata` are zero.
- R2: A 1 in `edge_pulse` at a clock edge sets the matching bit in the cause register of every CPU, visible from that edge on.
- R3: A write to a CPU's cause register clears each bit whose write-data bit is 0 and leaves each bit whose write-data bit is 1 unchanged. If an edge pulse for the same bit arrives in the same cycle, the bit ends up set.
- R4: A write to a CPU's edge-mask or level-mask register replaces the whole register with the write data.
- R5: The request of line i for CPU n is (`level_in`[i] AND level mask n[i]) OR (cause n[i] AND edge mask n[i]). The value is taken from the register state and `level_in` at a clock edge, and it appears on `irq_grp` after that edge.
- R6: Register map, using byte offsets with the low two address bits zero: CPU n's edge cause is at n*4, its edge mask at 0x10+n*4 and its level mask at 0x20+n*4. `acc_rdata` shows, after a clock edge, the register addressed at that edge, with the value it held before that edge.
- R7: A write addressed to one CPU's register changes no register of any other CPU, and no other register of the same CPU.
- R8: Unused offsets return zero on `acc_rdata`, and writes to them change no register. Unused offsets are those with a nonzero low two bits, and those at 0x30 and above.
- R9: `irq_grp`[n*4+g] is the OR of CPU n's requests for lines 8g to 8g+7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| edge_pulse | input | 32 | One-cycle edge event per line from the shared detector |
| level_in | input | 32 | Polarity-corrected line levels |
| acc_we | input | 1 | Register write strobe |
| acc_addr | input | 8 | Byte offset in the per-CPU window |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| irq_grp | output | 16 | Grouped interrupt outputs, four per CPU |

## Verification
The bench builds the block with its defaults: four CPUs, 32 lines and groups of eight. With these values every address region, every CPU index and every group output is reached, including the top group of the last CPU. The 8-bit address also reaches the unused region at 0x30 and above, as well as misaligned offsets. A behavioural model of all twelve registers predicts the read data and all sixteen group outputs at every clock. Directed phases cover a clear that collides with an edge pulse and writes that are not shared between CPUs, and a random phase mixes all of them.

// File: rtl/gpio_pcpu_pkg.sv
package gpio_pcpu_pkg;
  typedef enum logic [1:0] {
    RG_CAUSE = 2'd0,
    RG_EMASK = 2'd1,
    RG_LMASK = 2'd2,
    RG_NONE  = 2'd3
  } region_e;
endpackage

// File: rtl/gpio_pcpu_group_or.sv
module gpio_pcpu_group_or #(
  parameter int LINES = 32,
  parameter int GRP   = 8,
  localparam int NGRP = LINES / GRP
) (
  input  logic [LINES-1:0] req,
  output logic [NGRP-1:0]  grp
);
  for (genvar g = 0; g < NGRP; g++) begin : g_or
    assign grp[g] = |req[g*GRP +: GRP];
  end
endmodule

// File: rtl/gpio_pcpu_slice.sv
module gpio_pcpu_slice #(
  parameter int LINES = 32,
  parameter int GRP   = 8,
  localparam int NGRP = LINES / GRP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] edge_pulse,
  input  logic [LINES-1:0] level_in,
  input  logic             we_cause,
  input  logic             we_emask,
  input  logic             we_lmask,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] cause_q,
  output logic [LINES-1:0] emask_q,
  output logic [LINES-1:0] lmask_q,
  output logic [NGRP-1:0]  grp_q
);
  logic [LINES-1:0] req;
  logic [NGRP-1:0]  grp_c;
  logic [LINES-1:0] cause_kept;

  assign req        = (level_in & lmask_q) | (cause_q & emask_q);
  assign cause_kept = we_cause ? (cause_q & wdata) : cause_q;

  gpio_pcpu_group_or #(.LINES(LINES), .GRP(GRP)) u_grp (
    .req (req),
    .grp (grp_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      emask_q <= '0;
      lmask_q <= '0;
      grp_q   <= '0;
    end else begin
      cause_q <= cause_kept | edge_pulse;
      if (we_emask) emask_q <= wdata;
      if (we_lmask) lmask_q <= wdata;
      grp_q <= grp_c;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (cause_q == '0 && emask_q == '0 && lmask_q == '0 && grp_q == '0)); // R1
  AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (rst)
    (|edge_pulse) |=> ((cause_q & $past(edge_pulse)) == $past(edge_pulse))); // R2
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (rst)
    !we_cause |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R3
  AST_MASKS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!we_emask && !we_lmask) |=> ($stable(emask_q) && $stable(lmask_q))); // R4
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (emask_q == '0 && lmask_q == '0) |=> (grp_q == '0)); // R5
endmodule

// File: rtl/gpio_pcpu_irq_bank.sv
module gpio_pcpu_irq_bank #(
  parameter int NUM_CPU = 4,
  parameter int LINES   = 32,
  parameter int GRP     = 8,
  parameter int ADDR_W  = 8,
  localparam int NGRP   = LINES / GRP,
  localparam int CPU_W  = $clog2(NUM_CPU),
  localparam int TOP_B  = CPU_W + 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LINES-1:0]        edge_pulse,
  input  logic [LINES-1:0]        level_in,
  input  logic                    acc_we,
  input  logic [ADDR_W-1:0]       acc_addr,
  input  logic [LINES-1:0]        acc_wdata,
  output logic [LINES-1:0]        acc_rdata,
  output logic [NUM_CPU*NGRP-1:0] irq_grp
);
  import gpio_pcpu_pkg::*;

  logic             aligned;
  logic             upper_zero;
  logic             addr_hit;
  logic [CPU_W-1:0] cpu_idx;
  region_e          region;

  logic [LINES-1:0] cause_a [NUM_CPU];
  logic [LINES-1:0] emask_a [NUM_CPU];
  logic [LINES-1:0] lmask_a [NUM_CPU];
  logic [NUM_CPU-1:0] we_c, we_e, we_l;
  logic [LINES-1:0] rd_c;

  assign aligned = (acc_addr[1:0] == 2'b00);
  assign cpu_idx = acc_addr[CPU_W+1:2];
  assign region  = region_e'(acc_addr[CPU_W+3:CPU_W+2]);

  if (ADDR_W > TOP_B) begin : g_upper
    assign upper_zero = (acc_addr[ADDR_W-1:TOP_B] == '0);
  end else begin : g_noupper
    assign upper_zero = 1'b1;
  end

  assign addr_hit = aligned && upper_zero && (region != RG_NONE);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic sel;
    assign sel     = acc_we && addr_hit && (cpu_idx == CPU_W'(c));
    assign we_c[c] = sel && (region == RG_CAUSE);
    assign we_e[c] = sel && (region == RG_EMASK);
    assign we_l[c] = sel && (region == RG_LMASK);

    gpio_pcpu_slice #(.LINES(LINES), .GRP(GRP)) u_slice (
      .clk        (clk),
      .rst        (rst),
      .edge_pulse (edge_pulse),
      .level_in   (level_in),
      .we_cause   (we_c[c]),
      .we_emask   (we_e[c]),
      .we_lmask   (we_l[c]),
      .wdata      (acc_wdata),
      .cause_q    (cause_a[c]),
      .emask_q    (emask_a[c]),
      .lmask_q    (lmask_a[c]),
      .grp_q      (irq_grp[c*NGRP +: NGRP])
    );
  end

  always_comb begin
    rd_c = '0;
    if (addr_hit) begin
      unique case (region)
        RG_CAUSE: rd_c = cause_a[cpu_idx];
        RG_EMASK: rd_c = emask_a[cpu_idx];
        RG_LMASK: rd_c = lmask_a[cpu_idx];
        default:  rd_c = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc_rdata <= '0;
    else     acc_rdata <= rd_c;
  end

  AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !addr_hit |=> (acc_rdata == '0)); // R8
  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $countones({we_c, we_e, we_l}) <= 1); // R7
  AST_NO_WRITE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !acc_we |-> ({we_c, we_e, we_l} == '0)); // R6
endmodule

// File: tb/gpio_pcpu_irq_bank_tb.sv
module gpio_pcpu_irq_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] edge_pulse = '0;
  logic [31:0] level_in = '0;
  logic        acc_we = 1'b0;
  logic [7:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic [15:0] irq_grp;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [31:0] m_c [4];
  logic [31:0] m_e [4];
  logic [31:0] m_l [4];
  logic [15:0] exp_irq = '0;
  logic [31:0] exp_rd = '0;

  always #5 clk = ~clk;

  gpio_pcpu_irq_bank u_dut (
    .clk(clk), .rst(rst), .edge_pulse(edge_pulse), .level_in(level_in),
    .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .irq_grp(irq_grp)
  );

  function automatic logic [31:0] model_read(logic [7:0] a);
    int r, c;
    if ((a % 4) != 0 || a >= 8'h30) return 32'h0;
    r = a / 16;
    c = (a % 16) / 4;
    if (r == 0) return m_c[c];
    if (r == 1) return m_e[c];
    return m_l[c];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 4; c++) begin
        m_c[c] = '0; m_e[c] = '0; m_l[c] = '0;
      end
      exp_irq = '0;
      exp_rd = '0;
    end else begin
      exp_rd = model_read(acc_addr);
      for (int c = 0; c < 4; c++) begin
        for (int g = 0; g < 4; g++) begin
          logic any;
          any = 1'b0;
          for (int b = g*8; b < g*8+8; b++)
            if ((level_in[b] && m_l[c][b]) || (m_c[c][b] && m_e[c][b])) any = 1'b1;
          exp_irq[c*4+g] = any;
        end
      end
      for (int c = 0; c < 4; c++) begin
        if (acc_we && acc_addr == 8'(c*4))        m_c[c] = m_c[c] & acc_wdata;
        if (acc_we && acc_addr == 8'(16 + c*4))   m_e[c] = acc_wdata;
        if (acc_we && acc_addr == 8'(32 + c*4))   m_l[c] = acc_wdata;
        m_c[c] = m_c[c] | edge_pulse;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s (%s) at %0t: actual=%h expected=%h", tag, cur_req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R6 rdata", acc_rdata, exp_rd);
      chk("R5/R9 irq_grp", {16'h0, irq_grp}, {16'h0, exp_irq});
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    acc_we = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a);
    @(negedge clk);
    acc_addr = a;
    @(negedge clk);
  endtask

  task automatic pulse(logic [31:0] p);
    @(negedge clk);
    edge_pulse = p;
    @(negedge clk);
    edge_pulse = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    @(negedge clk);
    chk("R1 reset irq", {16'h0, irq_grp}, 32'h0);
    chk("R1 reset rdata", acc_rdata, 32'h0);

    cur_req = "R4";
    for (int c = 0; c < 4; c++) begin
      wr(8'(16 + c*4), 32'h1111_0000 << c);
      wr(8'(32 + c*4), 32'h0000_00F0 >> c);
    end
    for (int c = 0; c < 4; c++) begin
      rd(8'(16 + c*4));
      rd(8'(32 + c*4));
    end

    cur_req = "R2";
    pulse(32'h8001_0101);
    for (int c = 0; c < 4; c++) rd(8'(c*4));

    cur_req = "R3";
    wr(8'h04, 32'hFFFF_FFFE);
    rd(8'h04); rd(8'h00);
    @(negedge clk);
    acc_we = 1'b1; acc_addr = 8'h08; acc_wdata = 32'h0; edge_pulse = 32'h0000_0100;
    @(negedge clk);
    acc_we = 1'b0; edge_pulse = '0;
    rd(8'h08);

    cur_req = "R7";
    wr(8'h00, 32'h0);
    for (int a = 0; a < 48; a += 4) rd(8'(a));

    cur_req = "R8";
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    wr(8'h41, 32'hFFFF_FFFF);
    rd(8'h30); rd(8'h05); rd(8'hFC); rd(8'h13);
    for (int a = 0; a < 48; a += 4) rd(8'(a));

    cur_req = "R5";
    for (int c = 0; c < 4; c++) begin
      wr(8'(16 + c*4), 32'hFFFF_FFFF);
      wr(8'(32 + c*4), 32'h0101_0101 << c);
    end
    @(negedge clk); level_in = 32'h0000_0001;
    @(negedge clk); level_in = 32'h0200_0000;
    @(negedge clk); level_in = 32'hFFFF_FFFF;
    @(negedge clk); level_in = '0;

    cur_req = "R9";
    for (int c = 0; c < 4; c++) begin
      wr(8'(c*4), 32'h0);
      wr(8'(32 + c*4), 32'h0);
    end
    for (int b = 0; b < 32; b++) begin
      pulse(32'h1 << b);
      for (int c = 0; c < 4; c++) wr(8'(c*4), ~(32'h1 << b));
    end

    cur_req = "R3 random";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      edge_pulse = ($urandom % 4 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
      level_in = $urandom;
      acc_we = ($urandom % 3 == 0);
      acc_addr = ($urandom % 4 == 0) ? 8'($urandom) : 8'(($urandom % 12) * 4);
      acc_wdata = $urandom;
    end
    @(negedge clk);
    acc_we = 1'b0; edge_pulse = '0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule